// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus wrapped around a 4096 x 8 byte memory model. Both bus lines pass through a short synchronizer into the system clock domain. The block detects start and stop conditions from the synchronized lines. It recognizes its own address byte and then runs either a write transfer or a read transfer. SDA is open drain: the block only ever pulls the line low, through an output enable.

**Writes.** A write carries two address bytes followed by any number of data bytes. The data bytes are collected in a 32-byte page buffer. A stop condition that arrives after at least one data byte starts a nonvolatile programming cycle. That cycle is modelled as a counter of system clocks. While the cycle runs, the block refuses to acknowledge its address. A master can therefore poll with address bytes until an acknowledge comes back.

**Reads.** Reads start at the internal address pointer. The master can first set the pointer with a write that carries address bytes only. It can then read either after a stop or straight after a repeated start. The block keeps sending bytes for as long as the master acknowledges each one.

Top module: `eeprom_2w_slave`

## Requirements
- R1: The address byte is the 4-bit code 1010 (MSB first), then three select bits that must equal `dev_sel[2:0]`, then the R/W bit in bit 0. Any other value gets no acknowledge, and the block ignores the bus until the next start.
- R2: While `busy` is high, a matching address byte gets no acknowledge, whether its R/W bit is 0 or 1.
- R3: Once `busy` is low, a matching address byte is acknowledged and the transfer continues normally.
- R4: A stop that follows at least one written data byte raises `busy` for exactly WR_CYCLES clocks. A stop with no data byte leaves `busy` low. After reset, `busy` and `sda_oe` are low.
- R5: In a write, the first address byte supplies address bits 11..8 from its low nibble, and its upper nibble is ignored. The second address byte supplies bits 7..0.
- R6: A read sends its first byte from the pointer, MSB first, and the pointer holds the last accessed address plus one.
- R7: A read of address 4095 moves the pointer to 0.
- R8: A write to the last byte of a 32-byte page moves the pointer to the first byte of the same page. Later data bytes land there.
- R9: When the master acknowledges on the ninth clock of a read byte, the next byte follows. When it leaves SDA high, the block releases SDA and stays off the bus until a stop or start.
- R10: A start condition in any state restarts address-byte reception and drops data bytes that are not yet committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line as seen on the wire |
| dev_sel | input | 3 | Strap value matched against the select bits |
| sda_oe | output | 1 | Pull SDA low when high |
| busy | output | 1 | Programming cycle in progress |

## Verification
The end of the programming cycle can coincide with the acknowledge decision for an address byte. The bench provokes this by sending a read-mode address byte right after a write's stop, then polling with write-mode address bytes until one is acknowledged. Each refusal must fall while `busy` is high, and the first acknowledge must come with `busy` low. A second overlap occurs when the page pointer wraps in the same cycle as a data-byte acknowledge. That case is judged by reading back the wrapped location as the first byte of a current-address read.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

    localparam int ADDR_W     = 12;
    localparam int PAGE_W     = 5;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int HI_W       = ADDR_W - 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_DACK, S_AHI, S_AHACK, S_ALO, S_ALACK,
        S_WDAT, S_WACK, S_RDAT, S_RACK, S_HOLD
    } link_st_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic addr_t ptr_after_read(addr_t a);
        return a + 1'b1;
    endfunction

    function automatic addr_t ptr_after_write(addr_t a);
        return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + 1'b1};
    endfunction

endpackage

// File: rtl/ee2w_bus_sense.sv
module ee2w_bus_sense
    import ee2w_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic scl_d, sda_d, scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        ev.rise  = scl_s & ~scl_d;
        ev.fall  = ~scl_s & scl_d;
        ev.start = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop  = scl_s & scl_d & ~sda_d & sda_s;
        ev.sda   = sda_s;
    end

endmodule

// File: rtl/ee2w_link.sv
module ee2w_link
    import ee2w_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [2:0] dev_sel,
    input  logic       busy,
    input  logic [7:0] rd_data,
    output addr_t      ptr,
    output logic       sda_oe,
    output logic       wr_stb,
    output addr_t      wr_addr,
    output logic [7:0] wr_data,
    output logic       load_clr,
    output logic       commit
);
    link_st_e        st;
    logic [7:0]      sh, txb;
    logic [2:0]      cnt;
    logic            got, rw, loaded, mack;
    logic [HI_W-1:0] hi;

    always_ff @(posedge clk) begin
        wr_stb   <= 1'b0;
        commit   <= 1'b0;
        load_clr <= 1'b0;
        if (rst) begin
            st <= S_IDLE;  sh <= '0;  txb <= '0;  cnt <= '0;
            got <= 1'b0;   rw <= 1'b0; loaded <= 1'b0; mack <= 1'b0;
            hi <= '0;      ptr <= '0;  sda_oe <= 1'b0;
            wr_addr <= '0; wr_data <= '0;
        end else if (ev.start) begin
            st <= S_DEV;  cnt <= '0;  got <= 1'b0;
            sda_oe <= 1'b0;  loaded <= 1'b0;
        end else if (ev.stop) begin
            st <= S_IDLE;  sda_oe <= 1'b0;
            commit <= loaded;  loaded <= 1'b0;
        end else begin
            case (st)
                S_DEV, S_AHI, S_ALO, S_WDAT: begin
                    if (ev.rise) begin
                        sh  <= {sh[6:0], ev.sda};
                        cnt <= cnt + 3'd1;
                        if (cnt == 3'd7) got <= 1'b1;
                    end else if (ev.fall && got) begin
                        got <= 1'b0;
                        cnt <= '0;
                        case (st)
                            S_DEV: begin
                                if (sh[7:4] == DEV_CODE && sh[3:1] == dev_sel && !busy) begin
                                    rw <= sh[0];  sda_oe <= 1'b1;  st <= S_DACK;
                                end else begin
                                    st <= S_IDLE;
                                end
                            end
                            S_AHI: begin
                                hi <= sh[HI_W-1:0];  sda_oe <= 1'b1;  st <= S_AHACK;
                            end
                            S_ALO: begin
                                ptr <= {hi, sh};  sda_oe <= 1'b1;  st <= S_ALACK;
                            end
                            default: begin
                                wr_stb  <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= sh;
                                ptr     <= ptr_after_write(ptr);
                                loaded  <= 1'b1;
                                sda_oe  <= 1'b1;
                                st      <= S_WACK;
                            end
                        endcase
                    end
                end
                S_DACK: if (ev.fall) begin
                    if (rw) begin
                        txb <= rd_data;  sda_oe <= ~rd_data[7];  cnt <= '0;  st <= S_RDAT;
                    end else begin
                        sda_oe <= 1'b0;  st <= S_AHI;
                    end
                end
                S_AHACK: if (ev.fall) begin sda_oe <= 1'b0; st <= S_ALO; end
                S_ALACK: if (ev.fall) begin sda_oe <= 1'b0; st <= S_WDAT; load_clr <= 1'b1; end
                S_WACK:  if (ev.fall) begin sda_oe <= 1'b0; st <= S_WDAT; end
                S_RDAT: if (ev.fall) begin
                    if (cnt == 3'd7) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr_after_read(ptr);
                        st     <= S_RACK;
                    end else begin
                        cnt    <= cnt + 3'd1;
                        txb    <= {txb[6:0], 1'b0};
                        sda_oe <= ~txb[6];
                    end
                end
                S_RACK: begin
                    if (ev.rise) mack <= ~ev.sda;
                    else if (ev.fall) begin
                        if (mack) begin
                            txb <= rd_data;  sda_oe <= ~rd_data[7];  cnt <= '0;  st <= S_RDAT;
                        end else begin
                            st <= S_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R2: an address acknowledge is never given while programming runs
    a_r2_no_ack_busy: assert property (@(posedge clk) disable iff (rst)
        (st == S_DACK) |-> !busy);

    // R9: after a refused read byte the line stays released
    a_r9_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (st == S_HOLD) |-> !sda_oe);

    // R8: a data byte never moves the pointer out of its page
    a_r8_page_kept: assert property (@(posedge clk) disable iff (rst)
        (st == S_WDAT && ev.fall && got) |=>
        (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));

    // R7: reading the top address wraps the pointer to zero
    a_r7_read_wrap: assert property (@(posedge clk) disable iff (rst)
        (st == S_RDAT && ev.fall && cnt == 3'd7 && (&ptr)) |=> (ptr == '0));

endmodule

// File: rtl/ee2w_store.sv
module ee2w_store
    import ee2w_pkg::*;
#(
    parameter int WR_CYCLES = 10000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stb,
    input  addr_t      wr_addr,
    input  logic [7:0] wr_data,
    input  logic       load_clr,
    input  logic       commit,
    input  addr_t      rd_addr,
    output logic [7:0] rd_data,
    output logic       busy
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [7:0]              mem  [DEPTH];
    logic [7:0]              pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]   pval;
    logic [ADDR_W-PAGE_W-1:0] page_q;
    logic [CNT_W-1:0]        tmr;
    logic [PAGE_W:0]         walk;
    logic [PAGE_W-1:0]       widx;

    assign widx = walk[PAGE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pval   <= '0;
            page_q <= '0;
            tmr    <= '0;
            walk   <= '0;
            busy   <= 1'b0;
        end else begin
            if (load_clr) pval <= '0;
            if (wr_stb) begin
                pval[wr_addr[PAGE_W-1:0]] <= 1'b1;
                page_q <= wr_addr[ADDR_W-1:PAGE_W];
            end
            if (commit) begin
                busy <= 1'b1;
                tmr  <= CNT_W'(WR_CYCLES - 1);
                walk <= '0;
            end else if (busy) begin
                if (tmr == '0) busy <= 1'b0;
                else           tmr  <= tmr - 1'b1;
                if (!walk[PAGE_W]) walk <= walk + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_stb) pbuf[wr_addr[PAGE_W-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (busy && !walk[PAGE_W] && pval[widx])
            mem[{page_q, widx}] <= pbuf[widx];
    end

    assign rd_data = mem[rd_addr];

    // R4: a commit always starts the programming cycle
    a_r4_busy_on_commit: assert property (@(posedge clk) disable iff (rst)
        commit |=> busy);

    // R4: the cycle cannot end before its counter runs out
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && tmr != '0 && !commit) |=> busy);

endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave
    import ee2w_pkg::*;
#(
    parameter int WR_CYCLES   = 10000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] dev_sel,
    output logic       sda_oe,
    output logic       busy
);
    bus_ev_t    ev;
    addr_t      ptr, wr_addr;
    logic       wr_stb, load_clr, commit;
    logic [7:0] wr_data, rd_data;

    ee2w_bus_sense #(.STAGES(SYNC_STAGES)) u_sense (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    ee2w_link u_link (
        .clk(clk), .rst(rst), .ev(ev), .dev_sel(dev_sel), .busy(busy),
        .rd_data(rd_data), .ptr(ptr), .sda_oe(sda_oe), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .load_clr(load_clr), .commit(commit)
    );

    ee2w_store #(.WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .load_clr(load_clr), .commit(commit),
        .rd_addr(ptr), .rd_data(rd_data), .busy(busy)
    );

endmodule

// File: tb/eeprom_2w_slave_test.sv
module eeprom_2w_slave_test;
    localparam int WR = 600;
    localparam int Q  = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [2:0] sel = 3'b101;
    logic       sda_oe, busy;
    wire        sda = ~(m_low | sda_oe);

    eeprom_2w_slave #(.WR_CYCLES(WR)) uut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
        .dev_sel(sel), .sda_oe(sda_oe), .busy(busy)
    );

    always #5 clk = ~clk;

    int   checks = 0, fails = 0, blen = 0;
    logic busy_prev = 1'b0;
    logic [7:0] wdat [8];
    logic [7:0] DEVW, DEVR;

    always @(negedge clk) begin
        if (busy && !busy_prev) blen = 1;
        else if (busy) blen = blen + 1;
        busy_prev = busy;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart;
        m_low = 0; wt(Q); scl = 1; wt(Q); m_low = 1; wt(Q); scl = 0; wt(Q);
    endtask

    task automatic bstop;
        m_low = 1; wt(Q); scl = 1; wt(Q); m_low = 0; wt(Q);
    endtask

    task automatic wbit(input bit b);
        m_low = ~b; wt(Q); scl = 1; wt(Q); scl = 0; wt(Q);
    endtask

    task automatic rbit(output bit b);
        m_low = 0; wt(Q); scl = 1; wt(Q); b = sda; scl = 0; wt(Q);
    endtask

    task automatic sendb(input logic [7:0] v, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b);
        ack = !b;
    endtask

    task automatic recvb(input bit ackit, output logic [7:0] v);
        bit b;
        for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
        wbit(!ackit);
    endtask

    // write n bytes from wdat, then check the programming cycle and polling
    task automatic do_write(input logic [7:0] hi, input logic [7:0] lo, input int n);
        bit ack;
        int nacks;
        bstart;
        sendb(DEVW, ack); chk(ack, "R3 write address ack", ack, 1);
        sendb(hi, ack);   chk(ack, "R5 high address ack", ack, 1);
        sendb(lo, ack);   chk(ack, "R5 low address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            sendb(wdat[i], ack); chk(ack, "R8 data ack", ack, 1);
        end
        bstop;
        chk(busy == 1'b1, "R4 busy after stop", busy, 1);
        bstart;
        sendb(DEVR, ack); chk(!ack, "R2 read-mode address refused while busy", ack, 0);
        bstop;
        nacks = 1;
        for (int k = 0; k < 40; k++) begin
            bstart;
            sendb(DEVW, ack);
            if (ack) begin
                chk(busy == 1'b0, "R3 ack only after cycle end", busy, 0);
                bstop;
                break;
            end
            chk(busy == 1'b1, "R2 refusal only while busy", busy, 1);
            nacks++;
            bstop;
        end
        chk(nacks >= 2, "R2 polling saw refusals", nacks, 2);
        chk(blen == WR, "R4 busy length", blen, WR);
        chk(busy == 1'b0, "R4 no cycle after empty write", busy, 0);
    endtask

    task automatic set_ptr(input logic [7:0] hi, input logic [7:0] lo);
        bit ack;
        bstart;
        sendb(DEVW, ack); chk(ack, "R3 dummy write ack", ack, 1);
        sendb(hi, ack);
        sendb(lo, ack);   chk(ack, "R5 pointer load ack", ack, 1);
    endtask

    initial begin : main
        bit ack, b;
        logic [7:0] v;
        bit quiet;
        DEVW = {4'b1010, sel, 1'b0};
        DEVR = {4'b1010, sel, 1'b1};
        wt(5); rst = 0; wt(5);
        chk(sda_oe == 1'b0, "R4 reset sda_oe", sda_oe, 0);
        chk(busy == 1'b0, "R4 reset busy", busy, 0);

        // R1: select mismatch and code mismatch are refused
        for (int s = 0; s < 8; s++) begin
            bstart;
            sendb({4'b1010, 3'(s), 1'b0}, ack);
            chk(ack == (s == sel), "R1 select match", ack, (s == sel));
            bstop;
        end
        bstart; sendb({4'b1011, sel, 1'b0}, ack);
        chk(!ack, "R1 code mismatch", ack, 0); bstop;
        bstart; sendb({4'b0010, sel, 1'b1}, ack);
        chk(!ack, "R1 code mismatch read", ack, 0); bstop;
        wt(4);
        chk(busy == 1'b0, "R4 no cycle without data", busy, 0);

        wdat[0] = 8'h5A;
        do_write(8'h00, 8'h00, 1);

        for (int i = 0; i < 6; i++) wdat[i] = 8'h10 + 8'(i);
        do_write(8'hF1, 8'h3C, 6);   // R5: upper nibble ignored, 0x13C
        for (int i = 0; i < 4; i++) wdat[i] = 8'hA0 + 8'(i);
        do_write(8'h01, 8'h3C, 4);   // R8: pointer ends at 0x120

        // R6/R8: current-address read starts at the page-wrapped pointer
        bstart;
        sendb(DEVR, ack); chk(ack, "R6 read address ack", ack, 1);
        recvb(1, v); chk(v == 8'h14, "R8 pointer wrapped in page", v, 8'h14);
        recvb(0, v); chk(v == 8'h15, "R9 sequential byte after ack", v, 8'h15);
        quiet = 1;
        for (int i = 0; i < 9; i++) begin rbit(b); if (!b) quiet = 0; end
        chk(quiet, "R9 line released after nack", quiet, 1);
        bstop;

        // R10: repeated start after pointer load, R5 masked upper nibble
        set_ptr(8'hA1, 8'h3C);
        bstart;
        sendb(DEVR, ack); chk(ack, "R10 repeated start read ack", ack, 1);
        for (int i = 0; i < 4; i++) begin
            recvb(i < 3, v);
            chk(v == 8'hA0 + 8'(i), "R6 sequential read data", v, 8'hA0 + i);
        end
        bstop;
        wt(4);
        chk(busy == 1'b0, "R4 pointer-only write starts no cycle", busy, 0);

        // R7: read across the top of the array
        wdat[0] = 8'h77;
        do_write(8'h0F, 8'hFF, 1);
        set_ptr(8'h0F, 8'hFF);
        bstop;
        bstart;
        sendb(DEVR, ack); chk(ack, "R6 current read ack", ack, 1);
        recvb(1, v); chk(v == 8'h77, "R6 byte at 0xFFF", v, 8'h77);
        recvb(1, v); chk(v == 8'h5A, "R7 wrap to address 0", v, 8'h5A);
        recvb(0, v);
        bstop;

        // R10: start mid data phase discards uncommitted bytes
        set_ptr(8'h00, 8'h00);
        sendb(8'hEE, ack); chk(ack, "R10 data ack before restart", ack, 1);
        bstart;
        bstop;
        wt(4);
        chk(busy == 1'b0, "R10 aborted load not committed", busy, 0);
        set_ptr(8'h00, 8'h00);
        bstart;
        sendb(DEVR, ack);
        recvb(0, v); chk(v == 8'h5A, "R10 memory unchanged", v, 8'h5A);
        bstop;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule